// File: doc/BRIEF.md
# Compressed-Instruction Immediate ALU Execute Stage

This block executes two families of 16-bit compressed instructions in a single cycle. The first family shifts a register left, right (logical) or right (arithmetic) by an amount held in a 5-bit immediate field. The second family moves, compares, adds or subtracts an 8-bit unsigned immediate against one register. The register index to read is decoded combinationally from the instruction and presented on a read port. The block registers the write-back request (enable, index, data) and a per-flag update request for the N, Z, C and V condition flags at the next clock edge.

The surrounding pipeline owns the register file and the flag register. It applies a write-back when `wb_en` is high and applies each flag whose bit in `flag_we` is high. The current carry flag comes in on `carry_in`. The C bit of `flag_val` always carries the carry value that holds after the instruction, whether or not C was rewritten. Any opcode outside the two families, and any cycle without `exec_en`, leaves both the register file and the flags alone.

Top module: `cimm_exec`

## Requirements
- R1: Opcode select uses instr[15:11]: 00000 shift-left, 00001 logical shift-right, 00010 arithmetic shift-right, 00100 move, 00101 compare, 00110 add, 00111 subtract. Any other value, or `exec_en` low, gives `wb_en`=0 and `flag_we`=0 on the next cycle.
- R2: `rf_raddr` follows the instruction combinationally. It is instr[5:3] for the shift family and instr[10:8] for the immediate family.
- R3: A shift writes its result to register instr[2:0] and writes N (result bit 31) and Z (result zero). It never writes V.
- R4: A left shift with amount field instr[10:6] = 0 writes the source unchanged, does not write C (`flag_we`[1]=0), and reports `flag_val`[1] = `carry_in`.
- R5: A right shift (logical or arithmetic) with amount field 0 shifts by 32. C takes source bit 31. The result is 0 for logical, or source bit 31 copied into all bits for arithmetic.
- R6: A shift with a nonzero amount writes C with the last bit shifted out.
- R7: Move writes the immediate instr[7:0], zero-extended, to register instr[10:8]. It writes only N and Z (`flag_we`=1100).
- R8: Add writes register + immediate to register instr[10:8] and writes all four flags. C is the unsigned carry out and V is signed overflow.
- R9: Subtract writes register − immediate to register instr[10:8] and writes all four flags. C is 1 when no borrow occurs (register ≥ immediate, unsigned) and V is signed overflow.
- R10: Compare computes register − immediate and writes all four flags as subtract does, with `wb_en`=0.
- R11: Results appear one clock after the instruction is presented, so back-to-back instructions produce back-to-back results. Reset clears `wb_en`, `wb_idx`, `wb_data`, `flag_we` and `flag_val`.
- R12: `flag_we` and `flag_val` are ordered {N,Z,C,V}, from bit 3 down to bit 0. A bit of `flag_val` whose flag is not written is 0, except C, which then equals `carry_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_en | input | 1 | Instruction present this cycle |
| instr | input | 16 | Instruction word |
| carry_in | input | 1 | Current carry flag |
| rf_raddr | output | 3 | Register file read index |
| rf_rdata | input | XW | Register file read data |
| wb_en | output | 1 | Register write-back enable |
| wb_idx | output | 3 | Register write-back index |
| wb_data | output | XW | Register write-back data |
| flag_we | output | 4 | Per-flag update enable {N,Z,C,V} |
| flag_val | output | 4 | Flag values {N,Z,C,V} |

## Verification
The shifter's carry rule and the flag path for the same result land in one cycle. A zero-amount right shift must set C from bit 31 in the same cycle that Z or N is derived from the 32-place result. A zero-amount left shift must write N/Z while passing `carry_in` through on C without requesting a C write. The vector table provokes each case, with sources whose bit 31 and low bits differ, and judges `flag_we` and `flag_val` together with `wb_data` one clock later. A second pairing is compare against subtract: identical flag results, but only one write-back. Back-to-back issue checks that each result sits in its own cycle.

// File: rtl/cimm_exec.sv
module cimm_exec #(
  parameter int XW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exec_en,
  input  logic [15:0]   instr,
  input  logic          carry_in,
  output logic [2:0]    rf_raddr,
  input  logic [XW-1:0] rf_rdata,
  output logic          wb_en,
  output logic [2:0]    wb_idx,
  output logic [XW-1:0] wb_data,
  output logic [3:0]    flag_we,
  output logic [3:0]    flag_val
);
  localparam int AW = $clog2(XW) + 1;

  typedef enum logic [2:0] {
    OP_LSL, OP_LSR, OP_ASR, OP_MOV, OP_CMP, OP_ADD, OP_SUB, OP_NONE
  } op_e;

  op_e op;
  always_comb begin
    case (instr[15:11])
      5'b00000: op = OP_LSL;
      5'b00001: op = OP_LSR;
      5'b00010: op = OP_ASR;
      5'b00100: op = OP_MOV;
      5'b00101: op = OP_CMP;
      5'b00110: op = OP_ADD;
      5'b00111: op = OP_SUB;
      default:  op = OP_NONE;
    endcase
  end

  wire          imm_grp = (op == OP_MOV) || (op == OP_CMP) || (op == OP_ADD) || (op == OP_SUB);
  assign rf_raddr = imm_grp ? instr[10:8] : instr[5:3];

  wire [4:0]    sh_fld = instr[10:6];
  wire [AW-1:0] amt    = (sh_fld == 5'd0) ? AW'(XW) : AW'(sh_fld);
  wire [XW-1:0] imm    = XW'(instr[7:0]);

  wire [XW:0] lsl_w = {1'b0, rf_rdata} << sh_fld;
  wire [XW:0] lsr_w = {rf_rdata, 1'b0} >> amt;
  wire [XW:0] asr_w = $signed({rf_rdata, 1'b0}) >>> amt;
  wire [XW:0] sum_w = {1'b0, rf_rdata} + {1'b0, imm};
  wire [XW:0] dif_w = {1'b0, rf_rdata} - {1'b0, imm};

  wire a_s = rf_rdata[XW-1];
  wire i_s = imm[XW-1];
  wire add_v = (a_s == i_s) && (sum_w[XW-1] != a_s);
  wire sub_v = (a_s != i_s) && (dif_w[XW-1] != a_s);

  logic [XW-1:0] res;
  logic          c_new, v_new, wr;
  logic [3:0]    we;

  always_comb begin
    res = '0; c_new = 1'b0; v_new = 1'b0; wr = 1'b0; we = 4'b0000;
    if (exec_en) begin
      case (op)
        OP_LSL: begin
          res = lsl_w[XW-1:0]; c_new = lsl_w[XW]; wr = 1'b1;
          we = (sh_fld == 5'd0) ? 4'b1100 : 4'b1110;
        end
        OP_LSR: begin res = lsr_w[XW:1]; c_new = lsr_w[0]; wr = 1'b1; we = 4'b1110; end
        OP_ASR: begin res = asr_w[XW:1]; c_new = asr_w[0]; wr = 1'b1; we = 4'b1110; end
        OP_MOV: begin res = imm; wr = 1'b1; we = 4'b1100; end
        OP_CMP: begin res = dif_w[XW-1:0]; c_new = ~dif_w[XW]; v_new = sub_v; we = 4'b1111; end
        OP_ADD: begin res = sum_w[XW-1:0]; c_new = sum_w[XW]; v_new = add_v; wr = 1'b1; we = 4'b1111; end
        OP_SUB: begin res = dif_w[XW-1:0]; c_new = ~dif_w[XW]; v_new = sub_v; wr = 1'b1; we = 4'b1111; end
        default: ;
      endcase
    end
  end

  wire [2:0] dst = imm_grp ? instr[10:8] : instr[2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_en    <= 1'b0;
      wb_idx   <= 3'd0;
      wb_data  <= '0;
      flag_we  <= 4'b0000;
      flag_val <= 4'b0000;
    end else begin
      wb_en    <= wr;
      wb_idx   <= dst;
      wb_data  <= res;
      flag_we  <= we;
      flag_val <= {we[3] & res[XW-1], we[2] & (res == '0), we[1] ? c_new : carry_in, we[0] & v_new};
    end
  end

  a_r1_unknown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec_en || op == OP_NONE) |=> (!wb_en && flag_we == 4'b0000));

  a_r10_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && op == OP_CMP) |=> (!wb_en && flag_we == 4'b1111));

  a_r4_lsl0_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && op == OP_LSL && sh_fld == 5'd0) |=>
      (wb_data == $past(rf_rdata) && !flag_we[1] && flag_val[1] == $past(carry_in)));

  a_r7_mov_nz_only: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && op == OP_MOV) |=> (wb_en && flag_we == 4'b1100 && !flag_val[3]
      && wb_data[7:0] == $past(instr[7:0])));

  a_r9_sub_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && (op == OP_SUB || op == OP_CMP)) |=> (flag_val[1] == ($past(rf_rdata) >= $past(imm))));

  a_r3_nz_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && flag_we[3]) |-> (flag_val[3] == wb_data[XW-1] && flag_val[2] == (wb_data == '0)));

  a_r12_unwritten_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_val & ~flag_we & 4'b1101) == 4'b0000);
endmodule

// File: tb/sim_cimm_exec.sv
module sim_cimm_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec_en = 1'b0;
  logic [15:0] instr = 16'h0;
  logic        carry_in = 1'b0;
  logic [2:0]  rf_raddr;
  logic [31:0] rf_rdata;
  logic        wb_en;
  logic [2:0]  wb_idx;
  logic [31:0] wb_data;
  logic [3:0]  flag_we, flag_val;

  logic [31:0] rf [8];
  assign rf_rdata = rf[rf_raddr];

  always #2 clk = ~clk;

  cimm_exec #(.XW(32)) u0 (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .instr(instr), .carry_in(carry_in),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .wb_en(wb_en), .wb_idx(wb_idx),
    .wb_data(wb_data), .flag_we(flag_we), .flag_val(flag_val));

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [15:0] ins;
    logic [31:0] a;
    logic        cin;
    logic        wen;
    logic [2:0]  idx;
    logic [31:0] data;
    logic [3:0]  we;
    logic [3:0]  val;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VT [NV] = '{
    '{16'h0111, 32'h800000F1, 1'b0, 1'b1, 3'd1, 32'h00000F10, 4'b1110, 4'b0000, 4'd6},  // R6 R3
    '{16'h0047, 32'h80000000, 1'b0, 1'b1, 3'd7, 32'h00000000, 4'b1110, 4'b0110, 4'd6},  // R6
    '{16'h0023, 32'hF0000001, 1'b1, 1'b1, 3'd3, 32'hF0000001, 4'b1100, 4'b1010, 4'd4},  // R4
    '{16'h0A28, 32'h123456FF, 1'b0, 1'b1, 3'd0, 32'h00123456, 4'b1110, 4'b0010, 4'd6},  // R6
    '{16'h0832, 32'h80000000, 1'b0, 1'b1, 3'd2, 32'h00000000, 4'b1110, 4'b0110, 4'd5},  // R5
    '{16'h100C, 32'h80000001, 1'b0, 1'b1, 3'd4, 32'hFFFFFFFF, 4'b1110, 4'b1010, 4'd5},  // R5
    '{16'h111D, 32'h80000018, 1'b0, 1'b1, 3'd5, 32'hF8000001, 4'b1110, 4'b1010, 4'd6},  // R6
    '{16'h17FE, 32'h40000000, 1'b0, 1'b1, 3'd6, 32'h00000000, 4'b1110, 4'b0110, 4'd6},  // R6
    '{16'h2300, 32'h12345678, 1'b1, 1'b1, 3'd3, 32'h00000000, 4'b1100, 4'b0110, 4'd7},  // R7 R12
    '{16'h20FF, 32'hFFFFFFFF, 1'b0, 1'b1, 3'd0, 32'h000000FF, 4'b1100, 4'b0000, 4'd7},  // R7
    '{16'h2A05, 32'h00000005, 1'b0, 1'b0, 3'd2, 32'h0,        4'b1111, 4'b0110, 4'd10}, // R10
    '{16'h2901, 32'h00000000, 1'b1, 1'b0, 3'd1, 32'h0,        4'b1111, 4'b1000, 4'd10}, // R10
    '{16'h2C01, 32'h80000000, 1'b0, 1'b0, 3'd4, 32'h0,        4'b1111, 4'b0011, 4'd10}, // R10
    '{16'h3501, 32'h7FFFFFFF, 1'b0, 1'b1, 3'd5, 32'h80000000, 4'b1111, 4'b1001, 4'd8},  // R8
    '{16'h3610, 32'hFFFFFFF0, 1'b0, 1'b1, 3'd6, 32'h00000000, 4'b1111, 4'b0110, 4'd8},  // R8
    '{16'h3F20, 32'h00000010, 1'b1, 1'b1, 3'd7, 32'hFFFFFFF0, 4'b1111, 4'b1000, 4'd9},  // R9
    '{16'h3803, 32'h00000100, 1'b0, 1'b1, 3'd0, 32'h000000FD, 4'b1111, 4'b0010, 4'd9},  // R9
    '{16'h1800, 32'h00000001, 1'b1, 1'b0, 3'd0, 32'h0,        4'b0000, 4'b0010, 4'd1},  // R1 R12
    '{16'h4000, 32'h00000001, 1'b0, 1'b0, 3'd0, 32'h0,        4'b0000, 4'b0000, 4'd1}   // R1
  };

  task automatic load(input logic [15:0] ins, input logic [31:0] a, input logic cin, input logic en);
    logic [2:0] src;
    src = (ins[15:13] == 3'b001) ? ins[10:8] : ins[5:3];
    for (int k = 0; k < 8; k++) rf[k] = 32'hA5A50000 | k;
    rf[src] = a;
    instr = ins; carry_in = cin; exec_en = en;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) rf[k] = 32'h0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!wb_en && flag_we == 0 && flag_val == 0 && wb_data == 0, "R11 reset",
        {wb_en, flag_we, flag_val, wb_data}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [2:0] src;
      string tg;
      tg = $sformatf("R%0d vec%0d", VT[i].req, i);
      src = (VT[i].ins[15:13] == 3'b001) ? VT[i].ins[10:8] : VT[i].ins[5:3];
      load(VT[i].ins, VT[i].a, VT[i].cin, 1'b1);
      #1;
      if (VT[i].ins[15:14] == 2'b00)
        chk(rf_raddr == src, {"R2 raddr ", tg}, 64'(rf_raddr), 64'(src));
      @(negedge clk);
      chk(wb_en == VT[i].wen, {tg, " wen"}, 64'(wb_en), 64'(VT[i].wen));
      if (VT[i].wen)
        chk(wb_idx == VT[i].idx && wb_data == VT[i].data, {tg, " data"},
            {29'h0, wb_idx, wb_data}, {29'h0, VT[i].idx, VT[i].data});
      chk(flag_we == VT[i].we && flag_val == VT[i].val, {tg, " flags"},
          64'({flag_we, flag_val}), 64'({VT[i].we, VT[i].val}));
    end

    // R11 / R1: exec_en low with a valid add
    load(16'h3501, 32'h7FFFFFFF, 1'b0, 1'b0);
    @(negedge clk);
    chk(!wb_en && flag_we == 0, "R11 idle", {wb_en, flag_we}, 64'h0);

    // R11 back-to-back: add then subtract on consecutive cycles
    load(16'h3101, 32'h00000010, 1'b0, 1'b1);  // add r1,#1 -> 0x11
    @(negedge clk);
    chk(wb_en && wb_idx == 3'd1 && wb_data == 32'h11, "R11 b2b first",
        {wb_en, wb_idx, wb_data}, {1'b1, 3'd1, 32'h11});
    load(16'h3A02, 32'h00000001, 1'b0, 1'b1);  // sub r2,#2 -> 0xFFFFFFFF
    @(negedge clk);
    chk(wb_en && wb_idx == 3'd2 && wb_data == 32'hFFFFFFFF && flag_val == 4'b1000,
        "R11 b2b second", {flag_val, wb_data}, {4'b1000, 32'hFFFFFFFF});

    // R4 left shift by zero with carry_in low
    load(16'h0023, 32'h00000000, 1'b0, 1'b1);
    @(negedge clk);
    chk(flag_we == 4'b1100 && flag_val == 4'b0100 && wb_data == 0, "R4 lsl0 cin0",
        {flag_we, flag_val}, {4'b1100, 4'b0100});

    // R11 reset clears a pending result
    load(16'h20FF, 32'h0, 1'b0, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!wb_en && wb_data == 0 && flag_we == 0, "R11 async reset",
        {wb_en, flag_we, wb_data}, 64'h0);
    exec_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule